// File: doc/BRIEF.md
# Neighbor Buffer Ownership Swap Unit

This block sits on one link between two adjacent processing tiles of a 2D mesh, called tile A and tile B here. It holds two equal buffer banks and a single ownership bit. Each tile sees one plain synchronous memory port, and every access on that port is steered to the bank the tile owns at that moment. The address carries no bank-select bit, so a tile never knows which physical bank it is using.

Data passes to the neighbor without any copying. At a synchronization event a one-cycle swap pulse flips the ownership bit. From the next cycle on, each tile reads the bank the other tile filled before the event. A tile has four such links, one per compass direction, and this unit models one of them. A bypass input pins each tile to a fixed bank and makes the unit ignore swap pulses, for workloads that never talk to neighbors.

Top module: `nbr_swap_link`

## Requirements
- R1: After reset the ownership bit is 0, both read-data outputs are 0, and tile A owns bank 0 while tile B owns bank 1.
- R2: With the ownership bit at 0, A accesses bank 0 and B accesses bank 1. With the bit at 1, A accesses bank 1 and B accesses bank 0. The address alone selects the word within the owned bank.
- R3: One swap pulse exchanges the complete contents seen by the two tiles. Every address reads afterwards as the other tile's earlier data.
- R4: The ownership bit changes only in a cycle with the swap input high. Without a swap, stored data and ownership stay put over any number of idle cycles.
- R5: After a swap and until the next one, a tile's reads return the values the neighbor wrote before the swap.
- R6: Accesses in the same cycle as a swap pulse complete against the ownership that held before that cycle's clock edge.
- R7: A read (enable high, write-enable low) returns its data one cycle later. The read-data output holds its value in any cycle with no read on that port.
- R8: While bypass is high, A always uses bank 0 and B always uses bank 1, and swap pulses leave the ownership bit unchanged.
- R9: When bypass drops, steering follows the ownership bit as it stood before bypass was raised.
- R10: Two swap pulses restore the original ownership.
- R11: Both ports may access their banks in the same cycle without interfering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass_i | input | 1 | Fix A on bank 0 and B on bank 1, ignore swaps |
| swap_i | input | 1 | Synchronization pulse that flips ownership |
| a_en_i | input | 1 | Tile A access enable |
| a_we_i | input | 1 | Tile A write enable (read when low) |
| a_addr_i | input | AW | Tile A word address |
| a_wdata_i | input | DW | Tile A write data |
| a_rdata_o | output | DW | Tile A read data, one cycle after the read |
| b_en_i | input | 1 | Tile B access enable |
| b_we_i | input | 1 | Tile B write enable (read when low) |
| b_addr_i | input | AW | Tile B word address |
| b_wdata_i | input | DW | Tile B write data |
| b_rdata_o | output | DW | Tile B read data, one cycle after the read |

## Verification
The bench builds the unit with a data width of 16 and an address width of 3. Eight words per bank are few enough to fill and read back every address before and after a swap, so a swap that left any word behind shows up. The narrow data lets each word carry a tag for its writer and its address, which tells apart a correct swap, a missed swap and a bypass that leaks through.

// File: rtl/nbr_swap_pkg.sv
package nbr_swap_pkg;

  typedef enum logic {
    OWN_STRAIGHT = 1'b0,
    OWN_CROSSED  = 1'b1
  } own_e;

  function automatic logic bank_of(input logic port_idx, input own_e own, input logic bypass);
    return bypass ? port_idx : (port_idx ^ logic'(own));
  endfunction

endpackage

// File: rtl/nbr_swap_arb.sv
module nbr_swap_arb
  import nbr_swap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic swap_i,
  input  logic bypass_i,
  output own_e own_o
);

  own_e own_q;
  own_e own_d;
  logic flip_en;

  assign flip_en = swap_i & ~bypass_i;

  always_comb begin
    own_d = own_q;
    if (flip_en) own_d = (own_q == OWN_STRAIGHT) ? OWN_CROSSED : OWN_STRAIGHT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       own_q <= OWN_STRAIGHT;
    else if (flip_en) own_q <= own_d;
  end

  assign own_o = own_q;

  assert_swap_flips_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_i && !bypass_i) |=> (own_o != $past(own_o)));

  assert_no_swap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_i |=> $stable(own_o));

  assert_bypass_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_i |=> $stable(own_o));

endmodule

// File: rtl/nbr_swap_bank.sv
module nbr_swap_bank #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/nbr_swap_port.sv
module nbr_swap_port #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en_i,
  input  logic [DW-1:0] bank_rdata_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] rdata_q;
  logic [DW-1:0] rdata_d;

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en_i) rdata_d = bank_rdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_o));

endmodule

// File: rtl/nbr_swap_link.sv
module nbr_swap_link
  import nbr_swap_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bypass_i,
  input  logic          swap_i,
  input  logic          a_en_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic [DW-1:0] a_rdata_o,
  input  logic          b_en_i,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic [DW-1:0] b_rdata_o
);

  localparam int NPORT = 2;

  own_e          own;
  logic          p_en    [NPORT];
  logic          p_we    [NPORT];
  logic [AW-1:0] p_addr  [NPORT];
  logic [DW-1:0] p_wdata [NPORT];
  logic [DW-1:0] p_rdata [NPORT];
  logic [DW-1:0] bk_rdata[NPORT];

  assign p_en[0]    = a_en_i;
  assign p_we[0]    = a_we_i;
  assign p_addr[0]  = a_addr_i;
  assign p_wdata[0] = a_wdata_i;
  assign p_en[1]    = b_en_i;
  assign p_we[1]    = b_we_i;
  assign p_addr[1]  = b_addr_i;
  assign p_wdata[1] = b_wdata_i;
  assign a_rdata_o  = p_rdata[0];
  assign b_rdata_o  = p_rdata[1];

  nbr_swap_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .swap_i   (swap_i),
    .bypass_i (bypass_i),
    .own_o    (own)
  );

  for (genvar k = 0; k < NPORT; k++) begin : g_lane
    logic src;
    logic sel;

    // bank k is driven by the port that currently owns it
    assign src = bank_of(1'(k), own, bypass_i);
    // port k reads from the bank it currently owns
    assign sel = bank_of(1'(k), own, bypass_i);

    nbr_swap_bank #(.DW(DW), .AW(AW)) u_bank (
      .clk     (clk),
      .we_i    (p_en[src] & p_we[src]),
      .addr_i  (p_addr[src]),
      .wdata_i (p_wdata[src]),
      .rdata_o (bk_rdata[k])
    );

    nbr_swap_port #(.DW(DW)) u_port (
      .clk          (clk),
      .rst_n        (rst_n),
      .rd_en_i      (p_en[k] & ~p_we[k]),
      .bank_rdata_i (bk_rdata[sel]),
      .rdata_o      (p_rdata[k])
    );
  end

endmodule

// File: tb/test_nbr_swap_link.sv
module test_nbr_swap_link;

  localparam int DW = 16;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bypass_i, swap_i;
  logic          a_en_i, a_we_i, b_en_i, b_we_i;
  logic [AW-1:0] a_addr_i, b_addr_i;
  logic [DW-1:0] a_wdata_i, b_wdata_i, a_rdata_o, b_rdata_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nbr_swap_link #(.DW(DW), .AW(AW)) i_nbr_swap_link (
    .clk(clk), .rst_n(rst_n), .bypass_i(bypass_i), .swap_i(swap_i),
    .a_en_i(a_en_i), .a_we_i(a_we_i), .a_addr_i(a_addr_i), .a_wdata_i(a_wdata_i), .a_rdata_o(a_rdata_o),
    .b_en_i(b_en_i), .b_we_i(b_we_i), .b_addr_i(b_addr_i), .b_wdata_i(b_wdata_i), .b_rdata_o(b_rdata_o)
  );

  function automatic logic [DW-1:0] tag_a(input int addr);
    return 16'hA000 | 16'(addr);
  endfunction
  function automatic logic [DW-1:0] tag_b(input int addr);
    return 16'hB000 | 16'(addr);
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one clock cycle: inputs driven at negedge, results visible at next negedge
  task automatic cyc(input logic sw, input logic byp,
                     input logic ae, input logic awe, input int aad, input logic [DW-1:0] awd,
                     input logic be, input logic bwe, input int bad, input logic [DW-1:0] bwd);
    swap_i = sw; bypass_i = byp;
    a_en_i = ae; a_we_i = awe; a_addr_i = AW'(aad); a_wdata_i = awd;
    b_en_i = be; b_we_i = bwe; b_addr_i = AW'(bad); b_wdata_i = bwd;
    @(negedge clk);
    swap_i = 1'b0; a_en_i = 1'b0; b_en_i = 1'b0; a_we_i = 1'b0; b_we_i = 1'b0;
  endtask

  task automatic idle(input logic byp);
    cyc(1'b0, byp, 1'b0, 1'b0, 0, '0, 1'b0, 1'b0, 0, '0);
  endtask

  task automatic read_both(input logic byp, input int aad, input int bad);
    cyc(1'b0, byp, 1'b1, 1'b0, aad, '0, 1'b1, 1'b0, bad, '0);
  endtask

  task automatic t_reset_fill;
    check("R1 a_rdata after reset", a_rdata_o, '0);
    check("R1 b_rdata after reset", b_rdata_o, '0);
    for (int i = 0; i < DEPTH; i++)
      cyc(1'b0, 1'b0, 1'b1, 1'b1, i, tag_a(i), 1'b1, 1'b1, i, tag_b(i));
    for (int i = 0; i < DEPTH; i++) begin
      read_both(1'b0, i, DEPTH - 1 - i);
      check("R1 R11 A own bank0", a_rdata_o, tag_a(i));
      check("R2 R11 B own bank1", b_rdata_o, tag_b(DEPTH - 1 - i));
    end
  endtask

  task automatic t_swap_all;
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 0, '0, 1'b0, 1'b0, 0, '0);
    for (int i = 0; i < DEPTH; i++) begin
      read_both(1'b0, i, i);
      check("R3 R5 A sees B data", a_rdata_o, tag_b(i));
      check("R3 R5 B sees A data", b_rdata_o, tag_a(i));
    end
  endtask

  task automatic t_hold;
    for (int i = 0; i < 5; i++) idle(1'b0);
    check("R7 a_rdata held idle", a_rdata_o, tag_b(DEPTH - 1));
    check("R7 b_rdata held idle", b_rdata_o, tag_a(DEPTH - 1));
    read_both(1'b0, 2, 5);
    check("R4 no change A", a_rdata_o, tag_b(2));
    check("R4 no change B", b_rdata_o, tag_a(5));
  endtask

  task automatic t_same_cycle;
    // ownership bit is 1: A on bank1, B on bank0
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 0, 16'hC0C0, 1'b1, 1'b0, 2, '0);
    check("R6 B read in swap cycle uses old bank", b_rdata_o, tag_a(2));
    read_both(1'b0, 0, 0);
    check("R6 A after swap bank0", a_rdata_o, tag_a(0));
    check("R6 R5 B sees A write from swap cycle", b_rdata_o, 16'hC0C0);
  endtask

  task automatic t_double;
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 0, '0, 1'b0, 1'b0, 0, '0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 0, '0, 1'b0, 1'b0, 0, '0);
    read_both(1'b0, 1, 1);
    check("R10 A back on bank0", a_rdata_o, tag_a(1));
    check("R10 B back on bank1", b_rdata_o, tag_b(1));
  endtask

  task automatic t_bypass;
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 0, '0, 1'b0, 1'b0, 0, '0);  // bit now 1
    read_both(1'b1, 1, 1);
    check("R8 bypass A on bank0", a_rdata_o, tag_a(1));
    check("R8 bypass B on bank1", b_rdata_o, tag_b(1));
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 0, '0, 1'b0, 1'b0, 0, '0);
    read_both(1'b1, 3, 3);
    check("R8 swap ignored A", a_rdata_o, tag_a(3));
    check("R8 swap ignored B", b_rdata_o, tag_b(3));
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 4, 16'hD004, 1'b0, 1'b0, 0, '0);
    read_both(1'b0, 4, 4);
    check("R9 A resumes bank1", a_rdata_o, tag_b(4));
    check("R9 B resumes bank0", b_rdata_o, 16'hD004);
  endtask

  initial begin
    rst_n = 1'b0;
    swap_i = 1'b0; bypass_i = 1'b0;
    a_en_i = 1'b0; a_we_i = 1'b0; a_addr_i = '0; a_wdata_i = '0;
    b_en_i = 1'b0; b_we_i = 1'b0; b_addr_i = '0; b_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_fill();
    t_swap_all();
    t_hold();
    t_same_cycle();
    t_double();
    t_bypass();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule